// File: doc/BRIEF.md
# Predicate Guard Register File

This block keeps a bank of sixty-four single-bit predicates that decide whether issued operations are allowed to commit. A compare port evaluates one of two relations on a pair of 64-bit operands, either equality or signed less-than. On the next clock edge it writes the outcome into one predicate and the inverted outcome into a second predicate. The two predicates are addressed independently. This lets a then-path and an else-path of former branch code each be guarded by one predicate of the pair, and both paths can be issued in the same group.

Three issue slots each present a 6-bit predicate index and the write enable of their operation. For each slot the block returns the guard bit it read and a qualified write enable. An operation whose guard is false leaves with its enable forced low, so it cannot touch architectural state. Predicate zero is wired true and cannot be overwritten, which gives unconditional operations a guard that always passes.

Top module: `pred_guard_file`

## Requirements
- R1: After reset every predicate with index 1 to 63 reads 0 and predicate 0 reads 1.
- R2: With `cmp_kind` = 0 (equality) the compare result is 1 exactly when `cmp_a` equals `cmp_b`.
- R3: With `cmp_kind` = 1 (signed less-than) the result is 1 exactly when `cmp_a` is below `cmp_b` as two's-complement numbers. Equal operands give 0.
- R4: A compare with `cmp_valid` = 1 writes the result into predicate `cmp_dst_t` and its complement into predicate `cmp_dst_f` on the same rising edge.
- R5: Predicate 0 always reads 1. A compare that names it as either destination leaves it at 1, and the other destination is still written.
- R6: When `cmp_dst_t` equals `cmp_dst_f`, that predicate receives the result and not its complement.
- R7: A compare becomes readable only after the clock edge that accepts it. A read of the same predicate in the cycle of the compare returns the old value.
- R8: The three slots read independently. Slot s uses bits `rd_idx[6*s+5:6*s]` and returns its bit on `guard_out[s]`.
- R9: `op_we_out[s]` equals `op_we_in[s]` when `guard_out[s]` is 1, and is 0 when `guard_out[s]` is 0.
- R10: While `cmp_valid` is 0, no predicate changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request, writes on the next edge |
| cmp_kind | input | 1 | 0 = equality, 1 = signed less-than |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| cmp_dst_t | input | 6 | Predicate that receives the result |
| cmp_dst_f | input | 6 | Predicate that receives the complement |
| rd_idx | input | 18 | Three packed 6-bit guard indices, slot 0 in the low bits |
| op_we_in | input | 3 | Unqualified write enable per slot |
| guard_out | output | 3 | Guard bit read per slot |
| op_we_out | output | 3 | Write enable per slot after qualification by its guard |

## Verification
Two functions can meet in one cycle: a compare that writes a predicate, and a slot that reads that same predicate to qualify an enable. The bench applies both in the same cycle. It samples the guard and the qualified enable before the edge and expects the old value, then samples again after the edge and expects the new one. The second meeting is a compare whose two destinations coincide. Here the bench checks that the true destination wins, using both a true and a false outcome so that either ordering mistake shows.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_LT = 1'b1
    } cmp_kind_e;

endpackage

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pred_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  cmp_kind_e          kind,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic               hit
);

    logic same;
    logic below;

    always_comb begin
        same  = (opnd_a == opnd_b);
        below = ($signed(opnd_a) < $signed(opnd_b));
    end

    always_comb begin
        unique case (kind)
            CMP_EQ: hit = same;
            CMP_LT: hit = below;
        endcase
    end

    // R3: equal operands can never be below each other
    always_comb begin
        if (same && kind == CMP_LT) begin
            a_lt_equal_r3: assert (!hit);
        end
    end

endmodule

// File: rtl/pred_store.sv
module pred_store #(
    parameter int NUM   = 64,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_t,
    input  logic [IDX_W-1:0] wr_f,
    input  logic             wr_val,
    output logic [NUM-1:0]   bits
);

    localparam logic [NUM-1:0] RESET_IMAGE = {{(NUM-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= RESET_IMAGE;
        end else if (wr_en) begin
            for (int k = 1; k < NUM; k++) begin
                if (IDX_W'(k) == wr_t) begin
                    bits[k] <= wr_val;
                end else if (IDX_W'(k) == wr_f) begin
                    bits[k] <= ~wr_val;
                end
            end
        end
    end

    // R5: the hardwired entry never drops
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> bits[0]);

    // R10: no request, no change
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(bits));

    // R4: distinct nonzero targets end up complementary
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_t) != $past(wr_f)
         && $past(wr_t) != '0 && $past(wr_f) != '0)
        |-> (bits[$past(wr_t)] == $past(wr_val))
            && (bits[$past(wr_f)] == !$past(wr_val)));

    // R6: coinciding targets keep the result
    p_first_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_t) == $past(wr_f)
         && $past(wr_t) != '0)
        |-> bits[$past(wr_t)] == $past(wr_val));

endmodule

// File: rtl/pred_guard_slot.sv
module pred_guard_slot #(
    parameter int NUM   = 64,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   bits,
    input  logic [IDX_W-1:0] idx,
    input  logic             we_in,
    output logic             guard,
    output logic             we_out
);

    always_comb begin
        guard  = bits[idx];
        we_out = we_in & guard;
    end

endmodule

// File: rtl/pred_guard_file.sv
module pred_guard_file
    import pred_pkg::*;
#(
    parameter int NUM_PRED = 64,
    parameter int DATA_W   = 64,
    parameter int SLOTS    = 3,
    localparam int IDX_W   = $clog2(NUM_PRED)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmp_valid,
    input  logic                   cmp_kind,
    input  logic [DATA_W-1:0]      cmp_a,
    input  logic [DATA_W-1:0]      cmp_b,
    input  logic [IDX_W-1:0]       cmp_dst_t,
    input  logic [IDX_W-1:0]       cmp_dst_f,
    input  logic [SLOTS*IDX_W-1:0] rd_idx,
    input  logic [SLOTS-1:0]       op_we_in,
    output logic [SLOTS-1:0]       guard_out,
    output logic [SLOTS-1:0]       op_we_out
);

    logic           cmp_hit;
    logic [NUM_PRED-1:0] pred_bits;
    cmp_kind_e      kind_q;

    assign kind_q = cmp_kind_e'(cmp_kind);

    pred_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
        .kind   (kind_q),
        .opnd_a (cmp_a),
        .opnd_b (cmp_b),
        .hit    (cmp_hit)
    );

    pred_store #(.NUM(NUM_PRED), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_valid),
        .wr_t   (cmp_dst_t),
        .wr_f   (cmp_dst_f),
        .wr_val (cmp_hit),
        .bits   (pred_bits)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        pred_guard_slot #(.NUM(NUM_PRED), .IDX_W(IDX_W)) u_slot (
            .bits   (pred_bits),
            .idx    (rd_idx[s*IDX_W +: IDX_W]),
            .we_in  (op_we_in[s]),
            .guard  (guard_out[s]),
            .we_out (op_we_out[s])
        );

        // R5: index zero passes every operation
        p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[s*IDX_W +: IDX_W] == '0) |-> guard_out[s]);

        // R9: a false guard squashes the enable
        p_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !guard_out[s] |-> !op_we_out[s]);
    end

endmodule

// File: tb/tb_pred_guard_file.sv
module tb_pred_guard_file;

    localparam int NP = 64;
    localparam int DW = 64;
    localparam int NS = 3;
    localparam int IW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmp_valid = 1'b0;
    logic           cmp_kind = 1'b0;
    logic [DW-1:0]  cmp_a = '0;
    logic [DW-1:0]  cmp_b = '0;
    logic [IW-1:0]  cmp_dst_t = '0;
    logic [IW-1:0]  cmp_dst_f = '0;
    logic [NS*IW-1:0] rd_idx = '0;
    logic [NS-1:0]  op_we_in = '0;
    logic [NS-1:0]  guard_out;
    logic [NS-1:0]  op_we_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [NP-1:0] model;

    always #5 clk = ~clk;

    pred_guard_file dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .rd_idx(rd_idx), .op_we_in(op_we_in), .guard_out(guard_out),
        .op_we_out(op_we_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // bench-side expectation of one compare
    function automatic logic expect_hit(input logic kind, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
        if (kind) return $signed(a) < $signed(b);
        return a == b;
    endfunction

    task automatic do_cmp(input logic kind, input logic [DW-1:0] a,
                          input logic [DW-1:0] b, input int t, input int f);
        logic r;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_kind = kind; cmp_a = a; cmp_b = b;
        cmp_dst_t = IW'(t); cmp_dst_f = IW'(f);
        r = expect_hit(kind, a, b);
        @(negedge clk);
        cmp_valid = 1'b0;
        if (f != 0 && f != t) model[f] = ~r;
        if (t != 0) model[t] = r;
    endtask

    task automatic read3(input int i0, input int i1, input int i2);
        rd_idx = {IW'(i2), IW'(i1), IW'(i0)};
        #1;
    endtask

    task automatic t_reset();
        read3(0, 1, 63);
        check("R1 reset guards", {5'b0, guard_out}, 8'b001);
        read3(17, 0, 42);
        check("R8 slot order after reset", {5'b0, guard_out}, 8'b010);
    endtask

    task automatic t_equal();
        do_cmp(1'b0, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 5, 6);
        read3(5, 6, 0);
        check("R2 R4 equal true", {5'b0, guard_out}, {5'b0, 1'b1, model[6], model[5]});
        do_cmp(1'b0, 64'h1, 64'h8000_0000_0000_0001, 7, 8);
        read3(7, 8, 5);
        check("R2 R4 equal false", {5'b0, guard_out}, 8'b110);
    endtask

    task automatic t_less();
        do_cmp(1'b1, '1, 64'h1, 10, 11);
        read3(10, 11, 0);
        check("R3 -1 < 1", {5'b0, guard_out}, 8'b101);
        do_cmp(1'b1, 64'h1, '1, 12, 13);
        read3(12, 13, 0);
        check("R3 1 < -1", {5'b0, guard_out}, 8'b110);
        do_cmp(1'b1, 64'h55, 64'h55, 14, 15);
        read3(14, 15, 0);
        check("R3 equal operands", {5'b0, guard_out}, 8'b110);
        do_cmp(1'b1, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 16, 17);
        read3(16, 17, 0);
        check("R3 min < max", {5'b0, guard_out}, 8'b101);
    endtask

    task automatic t_zero();
        do_cmp(1'b0, 64'h3, 64'h4, 0, 18);
        read3(0, 18, 0);
        check("R5 zero as true dest", {5'b0, guard_out}, 8'b111);
        do_cmp(1'b0, 64'h3, 64'h3, 19, 0);
        read3(0, 19, 0);
        check("R5 zero as false dest", {5'b0, guard_out}, 8'b111);
    endtask

    task automatic t_same();
        do_cmp(1'b0, 64'h9, 64'h9, 20, 20);
        read3(20, 0, 0);
        check("R6 same dest true", {7'b0, guard_out[0]}, 8'd1);
        do_cmp(1'b0, 64'h9, 64'ha, 20, 20);
        read3(20, 0, 0);
        check("R6 same dest false", {7'b0, guard_out[0]}, 8'd0);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        read3(21, 22, 0);
        op_we_in = 3'b111;
        cmp_valid = 1'b1; cmp_kind = 1'b0; cmp_a = 64'h7; cmp_b = 64'h7;
        cmp_dst_t = 6'd21; cmp_dst_f = 6'd22;
        #1;
        check("R7 old value same cycle", {5'b0, guard_out}, 8'b100);
        check("R7 R9 old enables same cycle", {5'b0, op_we_out}, 8'b100);
        @(negedge clk);
        cmp_valid = 1'b0;
        model[21] = 1'b1; model[22] = 1'b0;
        #1;
        check("R7 new value after edge", {5'b0, guard_out}, 8'b101);
        op_we_in = 3'b000;
    endtask

    task automatic t_idle();
        @(negedge clk);
        cmp_valid = 1'b0; cmp_kind = 1'b0; cmp_a = 64'h1; cmp_b = 64'h1;
        cmp_dst_t = 6'd30; cmp_dst_f = 6'd5;
        repeat (3) @(negedge clk);
        read3(30, 5, 6);
        check("R10 idle writes nothing", {5'b0, guard_out}, {5'b0, model[6], model[5], model[30]});
    endtask

    task automatic t_guard();
        read3(5, 6, 0);
        op_we_in = 3'b111;
        #1;
        check("R9 mixed guards", {5'b0, op_we_out}, 8'b101);
        op_we_in = 3'b010;
        #1;
        check("R9 enable low stays low", {5'b0, op_we_out}, 8'b000);
        read3(6, 5, 63);
        op_we_in = 3'b110;
        #1;
        check("R8 R9 permuted slots", {5'b0, op_we_out}, 8'b010);
        op_we_in = 3'b000;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        model = {{(NP-1){1'b0}}, 1'b1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_equal();
        t_less();
        t_zero();
        t_same();
        t_bypass();
        t_idle();
        t_guard();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule